// File: doc/BRIEF.md
# Eight-Way Vote Tally Bank

This block keeps a running vote count for each of several candidates. On every clock, a candidate code and a vote-detect strobe arrive. The code is decoded into a one-hot write enable, and the enable is gated by the strobe. Only the register that belongs to the chosen candidate loads its own value plus one. The other registers keep their contents.

A second, independent select input drives a read multiplexer. The multiplexer places any one candidate's running total on the display output. A user can therefore watch one tally while votes for other candidates keep arriving.

The default build has a 3-bit code, which gives eight candidates, and 32-bit tallies. Both widths are parameters. The display path is purely combinational from the register bank. A synchronous, active-high reset clears the whole bank.

Top module: `vote_tally_bank`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, every tally becomes zero. Afterwards, `disp_o` reads 0 for every value of `sel_i`.
- R2: When `vote_i` is high and `rst_i` is low at a rising edge, the tally addressed by the binary value of `cand_i` increases by exactly one.
- R3: A vote changes only the addressed tally. All the other tallies keep their values across that edge.
- R4: When `vote_i` is low, no tally changes at the edge, whatever the value of `cand_i`.
- R5: `disp_o` always equals the tally addressed by the binary value of `sel_i`. It follows a change of `sel_i` without waiting for a clock edge.
- R6: A vote becomes visible on `disp_o` right after the clock edge that counts it, and not before that edge.
- R7: A tally that holds all ones becomes zero on its next counted vote. There is no saturation.
- R8: When reset and a vote arrive at the same edge, reset wins and the addressed tally becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high clear of all tallies |
| vote_i | input | 1 | Vote-detect strobe; high means count one vote this cycle |
| cand_i | input | CODE_W (3) | Binary code of the candidate that receives the vote |
| sel_i | input | CODE_W (3) | Binary code of the candidate whose total is shown |
| disp_o | output | CNT_W (32) | Running total of the selected candidate |

## Verification
The bench first sends single votes to one candidate while the display points at that candidate and then at the others. This separates a correct increment from one that leaks into neighbouring registers. Runs with the strobe low and a moving candidate code show whether the code alone can write. A long pseudo-random mix of strobe, code and display select, checked every cycle against a behavioural array of counters, catches decoder or multiplexer index mistakes. A second, 4-bit-wide instance is driven in parallel so that wrap-around at all ones can be reached in sixteen votes, and a reset that coincides with a vote shows which of the two takes priority.

// File: rtl/tally_pkg.sv
package tally_pkg;

    // Default geometry of the tally bank.
    localparam int unsigned TALLY_CODE_W = 3;
    localparam int unsigned TALLY_CNT_W  = 32;

    // Number of candidates addressed by a code of the given width.
    function automatic int unsigned cand_count(input int unsigned code_w);
        return 32'd1 << code_w;
    endfunction

endpackage

// File: rtl/tally_decoder.sv
// Turns the candidate code into a one-hot write enable gated by the strobe.
module tally_decoder #(
    parameter int unsigned CODE_W = tally_pkg::TALLY_CODE_W,
    localparam int unsigned N_CAND = tally_pkg::cand_count(CODE_W)
) (
    input  logic              strobe_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [N_CAND-1:0] wen_o
);

    for (genvar g = 0; g < N_CAND; g++) begin : g_line
        assign wen_o[g] = strobe_i && (code_i == CODE_W'(g));
    end

endmodule

// File: rtl/tally_cell.sv
// One candidate's counter: two-process style, synchronous clear, wraps on overflow.
module tally_cell #(
    parameter int unsigned CNT_W = tally_pkg::TALLY_CNT_W
) (
    input  logic             clk_i,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cell_state_t;

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    cell_state_t st_d;
    cell_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.count = '0;
        end else if (inc_i) begin
            st_d.count = st_q.count + STEP;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign count_o = st_q.count;

endmodule

// File: rtl/tally_readmux.sv
// Chooses one tally of the bank for the display output.
module tally_readmux #(
    parameter int unsigned CODE_W = tally_pkg::TALLY_CODE_W,
    parameter int unsigned CNT_W  = tally_pkg::TALLY_CNT_W,
    localparam int unsigned N_CAND = tally_pkg::cand_count(CODE_W)
) (
    input  logic [N_CAND-1:0][CNT_W-1:0] bank_i,
    input  logic [CODE_W-1:0]            sel_i,
    output logic [CNT_W-1:0]             word_o
);

    always_comb begin
        word_o = bank_i[sel_i];
    end

endmodule

// File: rtl/vote_tally_bank.sv
// Top level: decoder, bank of per-candidate counters, display multiplexer.
module vote_tally_bank #(
    parameter int unsigned CODE_W = tally_pkg::TALLY_CODE_W,
    parameter int unsigned CNT_W  = tally_pkg::TALLY_CNT_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              vote_i,
    input  logic [CODE_W-1:0] cand_i,
    input  logic [CODE_W-1:0] sel_i,
    output logic [CNT_W-1:0]  disp_o
);

    localparam int unsigned N_CAND = tally_pkg::cand_count(CODE_W);

    logic [N_CAND-1:0]            wen;
    logic [N_CAND-1:0][CNT_W-1:0] tally_bank;

    tally_decoder #(.CODE_W(CODE_W)) u_dec (
        .strobe_i (vote_i),
        .code_i   (cand_i),
        .wen_o    (wen)
    );

    for (genvar g = 0; g < N_CAND; g++) begin : g_cell
        tally_cell #(.CNT_W(CNT_W)) u_cell (
            .clk_i   (clk_i),
            .clr_i   (rst_i),
            .inc_i   (wen[g]),
            .count_o (tally_bank[g])
        );
    end

    tally_readmux #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_mux (
        .bank_i (tally_bank),
        .sel_i  (sel_i),
        .word_o (disp_o)
    );

endmodule

// File: rtl/vote_tally_bank_chk.sv
// Property checker, attached to every instance of the top module.
module vote_tally_bank_chk #(
    parameter int unsigned CODE_W = tally_pkg::TALLY_CODE_W,
    parameter int unsigned CNT_W  = tally_pkg::TALLY_CNT_W,
    localparam int unsigned N_CAND = tally_pkg::cand_count(CODE_W)
) (
    input logic                        clk_i,
    input logic                        rst_i,
    input logic                        vote_i,
    input logic [CODE_W-1:0]           cand_i,
    input logic [CODE_W-1:0]           sel_i,
    input logic [CNT_W-1:0]            disp_o,
    input logic [N_CAND-1:0][CNT_W-1:0] bank
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R1 R8
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (bank[cand_i] == '0) && (disp_o == '0));

    // R2 R7
    vote_incr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        vote_i |=> bank[$past(cand_i)] == $past(bank[cand_i]) + ONE);

    // R5
    display_sel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        disp_o == bank[sel_i]);

    for (genvar g = 0; g < N_CAND; g++) begin : g_hold
        // R3 R4
        hold_other_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            !(vote_i && (cand_i == CODE_W'(g))) |=> $stable(bank[g]));
    end

endmodule

bind vote_tally_bank vote_tally_bank_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .vote_i (vote_i),
    .cand_i (cand_i),
    .sel_i  (sel_i),
    .disp_o (disp_o),
    .bank   (tally_bank)
);

// File: tb/vote_tally_bank_bench.sv
`timescale 1ns/1ps
module vote_tally_bank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vote = 1'b0;
    logic [2:0]  cand = '0;
    logic [2:0]  sel = '0;
    logic [31:0] disp;
    logic [3:0]  disp_n;

    int compared = 0;
    int mismatched = 0;
    logic [31:0] mdl [8];
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    vote_tally_bank u_vote_tally_bank (
        .clk_i(clk), .rst_i(rst), .vote_i(vote), .cand_i(cand), .sel_i(sel), .disp_o(disp)
    );

    // Narrow copy on the same inputs: its tallies are the wide ones modulo 16.
    vote_tally_bank #(.CNT_W(4)) u_vote_tally_bank_narrow (
        .clk_i(clk), .rst_i(rst), .vote_i(vote), .cand_i(cand), .sel_i(sel), .disp_o(disp_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic compare_both(input string req);
        check(req, disp, mdl[sel]);
        check(req, {28'b0, disp_n}, {28'b0, mdl[sel][3:0]});
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge, compare just after.
    task automatic step(input logic r, input logic v, input logic [2:0] c, input logic [2:0] s,
                        input string req);
        @(negedge clk);
        rst = r; vote = v; cand = c; sel = s;
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 8; i++) mdl[i] = '0;
        end else if (v) begin
            mdl[c] = mdl[c] + 32'd1;
        end
        #1;
        compare_both(req);
    endtask

    // Walk the display select between edges with voting off.
    task automatic sweep(input string req);
        @(negedge clk);
        vote = 1'b0;
        for (int s = 0; s < 8; s++) begin
            sel = 3'(s);
            #0.4;
            compare_both(req);
        end
    endtask

    initial begin
        // R8: reset together with a vote.
        step(1'b1, 1'b1, 3'd3, 3'd3, "R8");
        step(1'b1, 1'b0, 3'd0, 3'd0, "R1");
        sweep("R1");

        // R2 / R3: a single vote, seen on the addressed and on another candidate.
        step(1'b0, 1'b1, 3'd2, 3'd2, "R2");
        step(1'b0, 1'b0, 3'd2, 3'd1, "R3");
        sweep("R3");

        // R4: the strobe is low while the code moves.
        for (int k = 0; k < 8; k++) step(1'b0, 1'b0, 3'(k), 3'd2, "R4");
        sweep("R4");

        // R6: not visible before the edge, visible right after it.
        @(negedge clk);
        rst = 1'b0; vote = 1'b1; cand = 3'd6; sel = 3'd6;
        #1;
        check("R6", disp, mdl[6]);
        @(posedge clk);
        mdl[6] = mdl[6] + 32'd1;
        #1;
        check("R6", disp, mdl[6]);

        // R2 R3 R5: pseudo-random mix, compared every cycle.
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(1'b0, lfsr[0] | lfsr[5], lfsr[3:1], lfsr[8:6], "R2");
        end
        sweep("R5");

        // R7: sixteen votes on one candidate wrap the 4-bit copy back to its start.
        step(1'b1, 1'b0, 3'd0, 3'd5, "R1");
        for (int k = 0; k < 15; k++) step(1'b0, 1'b1, 3'd5, 3'd5, "R7");
        check("R7", {28'b0, disp_n}, 32'hF);
        step(1'b0, 1'b1, 3'd5, 3'd5, "R7");
        check("R7", {28'b0, disp_n}, 32'h0);
        check("R7", disp, 32'd16);

        // R1: reset in mid-run clears everything.
        step(1'b0, 1'b1, 3'd1, 3'd1, "R2");
        step(1'b1, 1'b0, 3'd1, 3'd1, "R1");
        sweep("R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #2000000;
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule